// File: doc/BRIEF.md
# Linear-to-decibel converter (iterative hyperbolic CORDIC)

This block turns an unsigned fixed-point magnitude `lin_in` into its decibel value, 10·log10(w), as a signed fixed-point word. A request is made by pulsing `start`. The block then counts the leading zeros of the input and splits it into w = m·2^e, with a mantissa m in [1,2). The natural log of the mantissa comes from a hyperbolic CORDIC run in vectoring mode, through ln(m) = 2·atanh((m−1)/(m+1)).

The CORDIC registers are seeded with x = m+1, y = m−1 and z = 0. Each step adds or subtracts according to the sign of y, so that y is driven toward zero. Meanwhile z collects the angles atanh(2^−i). The step indices run from 1 upward, and indices 4, 13, 40, … are executed twice so the iteration converges. Doubling z gives ln(m). Adding e·ln 2 gives ln(w). One multiply by 10/ln 10 then gives decibels.

A single set of three adders is reused for every step, so one conversion takes many cycles but little area. A one-cycle `done` pulse marks the result. A zero input has no logarithm: it is reported through `invalid`, and the output takes the most negative code.

Top module: `lin2db_conv`

## Requirements
- R1: While reset is asserted and right after its release, `done` and `invalid` are 0 and `db_out` is 0.
- R2: For every nonzero integer input (IN_FRAC = 0), `db_out` equals 10·log10(w)·2^OUT_FRAC within ±1 LSB. The output is two's complement with OUT_FRAC fractional bits.
- R3: With IN_FRAC > 0, the input is read as w = lin_in / 2^IN_FRAC. Inputs below 1.0 give negative results, still within ±1 LSB of 10·log10(w)·2^OUT_FRAC.
- R4: `done` is high for exactly one cycle. It is high in the cycle that follows the edge that sampled `start` by STEPS+3 edges. STEPS is ITERS plus the number of values 4, 13, 40, … (k → 3k+1) that do not exceed ITERS. The latency is the same for every input, including zero.
- R5: A `start` pulse that arrives while a conversion is in progress is ignored. It changes neither the result nor the timing of the running conversion, and it produces no extra `done`.
- R6: An input of zero gives `invalid` = 1 and `db_out` = −2^(OUT_W−1).
- R7: A conversion of a nonzero input returns `invalid` = 0, even when the previous input was zero.
- R8: `db_out` and `invalid` keep their values from one `done` pulse to the next.
- R9: A `start` presented in the same cycle as `done` is accepted, and it completes with the normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion of `lin_in` (accepted only when idle) |
| lin_in | input | IN_W | Unsigned linear magnitude, IN_FRAC fractional bits |
| done | output | 1 | One-cycle pulse: `db_out` and `invalid` are updated |
| db_out | output | OUT_W | Signed result in dB, OUT_FRAC fractional bits |
| invalid | output | 1 | Set when the converted input was zero |

## Verification
Every result is due exactly STEPS+3 rising edges after the edge that sampled `start`. That is 27 edges for ITERS = 22, because indices 4 and 13 run twice. The bench derives this count itself from the repeat rule. After the start pulse it counts negative edges and reads `done`, `db_out` and `invalid` only at the falling edge of the cycle in which `done` rises, and it fails any conversion whose pulse comes earlier or later. Outside those cycles it looks at the outputs only to confirm that they hold and that no stray `done` appears. This covers the cycles after an ignored mid-conversion `start` and the idle cycles after a result.

// File: rtl/lin2db_pkg.sv
package lin2db_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_NORM  = 2'd1,
      ST_ITER  = 2'd2,
      ST_SCALE = 2'd3
   } l2d_state_e;

   // True when hyperbolic step index k has to be executed a second time.
   function automatic bit is_dup(input int k);
      int r;
      r = 4;
      while (r <= k) begin
         if (r == k) return 1'b1;
         r = 3 * r + 1;
      end
      return 1'b0;
   endfunction

   // Total number of CORDIC steps including the repeated indices.
   function automatic int step_count(input int iters);
      int n;
      n = iters;
      for (int r = 4; r <= iters; r = 3 * r + 1) n++;
      return n;
   endfunction

   // atanh(2^-i) scaled by 2^fb, rounded.
   function automatic int atanh_fx(input int i, input int fb);
      real t;
      real a;
      t = 1.0 / (2.0 ** i);
      a = 0.5 * $ln((1.0 + t) / (1.0 - t));
      return $rtoi(a * (2.0 ** fb) + 0.5);
   endfunction

   // Positive real constant scaled by 2^fb, rounded.
   function automatic int const_fx(input real v, input int fb);
      return $rtoi(v * (2.0 ** fb) + 0.5);
   endfunction

endpackage

// File: rtl/lin2db_norm.sv
module lin2db_norm #(
   parameter int IN_W = 16,
   localparam int PW  = $clog2(IN_W)
) (
   input  logic [IN_W-1:0] w,
   output logic [IN_W-1:0] mant,
   output logic [PW-1:0]   lead,
   output logic            is_zero
);

   // Leading-one detector: highest set bit wins.
   always_comb begin
      lead = '0;
      for (int b = 0; b < IN_W; b++) begin
         if (w[b]) lead = PW'(b);
      end
   end

   // Mantissa with its leading one moved to the MSB: 1.(IN_W-1) format.
   assign mant    = w << (IN_W - 1 - int'(lead));
   assign is_zero = (w == '0);

endmodule

// File: rtl/lin2db_cordic.sv
module lin2db_cordic
   import lin2db_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int FB    = 22,
   parameter int ITERS = 22,
   localparam int DW   = FB + 3,
   localparam int IW   = $clog2(ITERS + 1),
   localparam int MF   = IN_W - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [IN_W-1:0]      mant,
   input  logic [IW-1:0]        idx,
   output logic signed [DW-1:0] z
);

   localparam logic signed [DW-1:0] ONE = {2'b00, 1'b1, {FB{1'b0}}};

   logic signed [DW-1:0] x, y;
   logic signed [DW-1:0] m_fx;
   logic signed [DW-1:0] xs, ys;
   logic signed [DW-1:0] ang [0:ITERS];

   // Align the mantissa to FB fractional bits.
   if (FB >= MF) begin : g_align_up
      assign m_fx = $signed(DW'(mant) << (FB - MF));
   end else begin : g_align_dn
      assign m_fx = $signed(DW'(mant >> (MF - FB)));
   end

   // Angle table, computed at elaboration.
   assign ang[0] = '0;
   for (genvar g = 1; g <= ITERS; g++) begin : g_ang
      localparam int A = atanh_fx(g, FB);
      assign ang[g] = DW'(A);
   end

   assign xs = x >>> idx;
   assign ys = y >>> idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x <= '0;
         y <= '0;
         z <= '0;
      end else if (load) begin
         x <= m_fx + ONE;
         y <= m_fx - ONE;
         z <= '0;
      end else if (step) begin
         if (!y[DW-1]) begin
            x <= x - ys;
            y <= y - xs;
            z <= z + ang[idx];
         end else begin
            x <= x + ys;
            y <= y + xs;
            z <= z - ang[idx];
         end
      end
   end

endmodule

// File: rtl/lin2db_scale.sv
module lin2db_scale
   import lin2db_pkg::*;
#(
   parameter int FB        = 22,
   parameter int EW        = 6,
   parameter int OUT_W     = 16,
   parameter int OUT_FRAC  = 8,
   parameter int KF        = 18,
   parameter bit ROUND_OUT = 1'b1,
   localparam int DW       = FB + 3
) (
   input  logic signed [DW-1:0]    z,
   input  logic signed [EW-1:0]    e,
   input  logic                    zero,
   output logic signed [OUT_W-1:0] db
);

   localparam int LW = DW + EW + 1;
   localparam int KW = KF + 4;
   localparam int MW = LW + KW;
   localparam int SH = FB + KF - OUT_FRAC;

   localparam int LN2_I = const_fx(0.6931471805599453, FB);
   localparam int DBK_I = const_fx(4.342944819032518, KF);
   localparam logic signed [LW-1:0] LN2_C = LW'(LN2_I);
   localparam logic signed [KW-1:0] DBK_C = KW'(DBK_I);

   localparam logic signed [OUT_W-1:0] DB_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] DB_MIN = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic signed [MW-1:0] LIM_HI = $signed({{(MW-OUT_W){1'b0}}, DB_MAX});
   localparam logic signed [MW-1:0] LIM_LO = $signed({{(MW-OUT_W){1'b1}}, DB_MIN});

   logic signed [LW-1:0] lnw;
   logic signed [MW-1:0] prod;
   logic signed [MW-1:0] biased;
   logic signed [MW-1:0] shifted;

   always_comb begin
      lnw  = ($signed({{(LW-DW){z[DW-1]}}, z}) <<< 1)
           + $signed({{(LW-EW){e[EW-1]}}, e}) * LN2_C;
      prod = $signed({{(MW-LW){lnw[LW-1]}}, lnw})
           * $signed({{(MW-KW){DBK_C[KW-1]}}, DBK_C});
   end

   if (ROUND_OUT) begin : g_round
      assign biased = prod + (MW'(1) << (SH - 1));
   end else begin : g_trunc
      assign biased = prod;
   end

   always_comb begin
      shifted = biased >>> SH;
      if (zero)                 db = DB_MIN;
      else if (shifted > LIM_HI) db = DB_MAX;
      else if (shifted < LIM_LO) db = DB_MIN;
      else                       db = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/lin2db_conv.sv
module lin2db_conv
   import lin2db_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int IN_FRAC   = 0,
   parameter int FB        = 22,
   parameter int ITERS     = 22,
   parameter int OUT_W     = 16,
   parameter int OUT_FRAC  = 8,
   parameter int KF        = 18,
   parameter bit ROUND_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [IN_W-1:0]         lin_in,
   output logic                    done,
   output logic signed [OUT_W-1:0] db_out,
   output logic                    invalid
);

   localparam int PW = $clog2(IN_W);
   localparam int EW = $clog2(IN_W) + 2;
   localparam int IW = $clog2(ITERS + 1);
   localparam int DW = FB + 3;

   if (IN_W < 2) begin : g_chk_inw
      $error("lin2db_conv: IN_W must be at least 2");
   end
   if (IN_FRAC < 0 || IN_FRAC >= IN_W) begin : g_chk_frac
      $error("lin2db_conv: IN_FRAC out of range");
   end
   if (FB < 8 || FB > 28) begin : g_chk_fb
      $error("lin2db_conv: FB must lie in 8..28");
   end
   if (ITERS < 4 || ITERS > FB) begin : g_chk_iters
      $error("lin2db_conv: ITERS must lie in 4..FB");
   end
   if (KF < 8 || KF > 26) begin : g_chk_kf
      $error("lin2db_conv: KF must lie in 8..26");
   end
   if (FB + KF - OUT_FRAC < 1) begin : g_chk_sh
      $error("lin2db_conv: OUT_FRAC too large for FB+KF");
   end
   if (3.02 * IN_W * (2.0 ** OUT_FRAC) >= 2.0 ** (OUT_W - 1)) begin : g_chk_ow
      $error("lin2db_conv: OUT_W too narrow for the dB range");
   end

   l2d_state_e           state;
   logic [IN_W-1:0]      w_q;
   logic [IN_W-1:0]      mant;
   logic [PW-1:0]        lead;
   logic                 w_zero;
   logic                 zero_q;
   logic signed [EW-1:0] e_q;
   logic [IW-1:0]        idx;
   logic                 dup_done;
   logic [ITERS:0]       dup_tab;
   logic signed [DW-1:0] z;
   logic signed [OUT_W-1:0] db_next;
   logic                 last_step;

   for (genvar g = 0; g <= ITERS; g++) begin : g_dup
      localparam bit D = is_dup(g);
      assign dup_tab[g] = D;
   end

   assign last_step = (idx == IW'(ITERS)) && (!dup_tab[idx] || dup_done);

   lin2db_norm #(.IN_W(IN_W)) u_norm (
      .w       (w_q),
      .mant    (mant),
      .lead    (lead),
      .is_zero (w_zero)
   );

   lin2db_cordic #(.IN_W(IN_W), .FB(FB), .ITERS(ITERS)) u_cordic (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state == ST_NORM),
      .step  (state == ST_ITER),
      .mant  (mant),
      .idx   (idx),
      .z     (z)
   );

   lin2db_scale #(
      .FB(FB), .EW(EW), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC),
      .KF(KF), .ROUND_OUT(ROUND_OUT)
   ) u_scale (
      .z    (z),
      .e    (e_q),
      .zero (zero_q),
      .db   (db_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         w_q      <= '0;
         e_q      <= '0;
         zero_q   <= 1'b0;
         idx      <= '0;
         dup_done <= 1'b0;
         done     <= 1'b0;
         invalid  <= 1'b0;
         db_out   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  w_q   <= lin_in;
                  state <= ST_NORM;
               end
            end
            ST_NORM: begin
               e_q      <= $signed(EW'(lead)) - $signed(EW'(IN_FRAC));
               zero_q   <= w_zero;
               idx      <= IW'(1);
               dup_done <= 1'b0;
               state    <= ST_ITER;
            end
            ST_ITER: begin
               if (last_step) begin
                  state <= ST_SCALE;
               end else if (dup_tab[idx] && !dup_done) begin
                  dup_done <= 1'b1;
               end else begin
                  dup_done <= 1'b0;
                  idx      <= idx + 1'b1;
               end
            end
            ST_SCALE: begin
               db_out  <= db_next;
               invalid <= zero_q;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lin2db_conv_chk.sv
module lin2db_conv_chk
   import lin2db_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int ITERS = 22,
   parameter int OUT_W = 16,
   localparam int IW   = $clog2(ITERS + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    done,
   input logic                    invalid,
   input logic signed [OUT_W-1:0] db_out,
   input l2d_state_e              state,
   input logic [IW-1:0]           idx,
   input logic [IN_W-1:0]         w_q
);

   localparam int LAT = step_count(ITERS) + 3;
   localparam logic signed [OUT_W-1:0] DB_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   int since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since <= 0;
      else if (start && state == ST_IDLE)  since <= 1;
      else if (since != 0 && since < 4096) since <= since + 1;
   end

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since == LAT));

   assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ITER) |-> (idx >= 1 && idx <= ITERS));

   assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE) |=> $stable(w_q));

   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (invalid == (w_q == '0)));

   assert_zero_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && invalid) |-> (db_out == DB_MIN));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(db_out) && $stable(invalid)));

endmodule

bind lin2db_conv lin2db_conv_chk #(
   .IN_W(IN_W), .ITERS(ITERS), .OUT_W(OUT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .done    (done),
   .invalid (invalid),
   .db_out  (db_out),
   .state   (state),
   .idx     (idx),
   .w_q     (w_q)
);

// File: tb/lin2db_conv_tb.sv
module lin2db_conv_tb;

   localparam int CLK_PERIOD = 10;
   localparam int A_W  = 10;
   localparam int B_W  = 8;
   localparam int B_FR = 6;
   localparam int FB_T = 22;
   localparam int IT_T = 22;
   localparam int OW   = 16;
   localparam int OF   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_a, start_b, done_a, done_b, inv_a, inv_b;
   logic [A_W-1:0] lin_a;
   logic [B_W-1:0] lin_b;
   logic signed [OW-1:0] db_a, db_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int lat_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   lin2db_conv #(.IN_W(A_W), .IN_FRAC(0), .FB(FB_T), .ITERS(IT_T),
                 .OUT_W(OW), .OUT_FRAC(OF)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start_a), .lin_in(lin_a),
      .done(done_a), .db_out(db_a), .invalid(inv_a));

   lin2db_conv #(.IN_W(B_W), .IN_FRAC(B_FR), .FB(FB_T), .ITERS(IT_T),
                 .OUT_W(OW), .OUT_FRAC(OF)) u_dut_frac (
      .clk(clk), .rst_n(rst_n), .start(start_b), .lin_in(lin_b),
      .done(done_b), .db_out(db_b), .invalid(inv_b));

   function automatic int exp_steps(input int n);
      int s;
      s = n;
      for (int r = 4; r <= n; r = 3 * r + 1) s++;
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %f expected %f", req, what, act, expv);
      end
   endtask

   task automatic check_db(input string req, input real w, input int act);
      real e;
      e = 10.0 * $log10(w) * (2.0 ** OF);
      chk((real'(act) - e) <= 1.0 && (e - real'(act)) <= 1.0, req, "dB value", real'(act), e);
   endtask

   task automatic wait_done_a(inout int lat);
      while (!done_a && lat < 400) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_a(input int w, output int db, output bit inv, output int lat);
      @(negedge clk);
      lin_a = w[A_W-1:0];
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      lat = 1;
      wait_done_a(lat);
      db = db_a;
      inv = inv_a;
   endtask

   task automatic run_b(input int w, output int db, output bit inv, output int lat);
      @(negedge clk);
      lin_b = w[B_W-1:0];
      start_b = 1'b1;
      @(negedge clk);
      start_b = 1'b0;
      lat = 1;
      while (!done_b && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      db = db_b;
      inv = inv_b;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
         end
      end
   end

   initial begin
      int db, lat, extra, held;
      bit inv;
      start_a = 1'b0;
      start_b = 1'b0;
      lin_a = '0;
      lin_b = '0;
      lat_exp = exp_steps(IT_T) + 3;

      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      chk(done_a == 0 && inv_a == 0 && db_a == 0, "R1", "outputs in reset", real'(db_a), 0.0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_b == 0 && inv_b == 0 && db_b == 0, "R1", "outputs after reset", real'(db_b), 0.0);

      // R2 / R4 / R7: exhaustive integer sweep
      for (int w = 1; w < (1 << A_W); w++) begin
         run_a(w, db, inv, lat);
         check_db("R2", real'(w), db);
         chk(lat == lat_exp, "R4", "latency", real'(lat), real'(lat_exp));
         chk(!inv, "R7", "invalid on nonzero", real'(inv), 0.0);
      end

      // R3 / R4: exhaustive fractional-input sweep (values below and above 1.0)
      for (int w = 1; w < (1 << B_W); w++) begin
         run_b(w, db, inv, lat);
         check_db("R3", real'(w) / (2.0 ** B_FR), db);
         chk(lat == lat_exp, "R4", "latency frac", real'(lat), real'(lat_exp));
      end

      // R6: zero input on both configurations, same latency (R4)
      run_a(0, db, inv, lat);
      chk(inv == 1'b1, "R6", "invalid on zero", real'(inv), 1.0);
      chk(db == -(1 << (OW-1)), "R6", "zero code", real'(db), -(2.0 ** (OW-1)));
      chk(lat == lat_exp, "R4", "latency zero", real'(lat), real'(lat_exp));
      run_b(0, db, inv, lat);
      chk(inv == 1'b1 && db == -(1 << (OW-1)), "R6", "zero frac", real'(db), -(2.0 ** (OW-1)));

      // R7: nonzero after zero clears invalid
      run_a(1000, db, inv, lat);
      chk(!inv, "R7", "invalid cleared", real'(inv), 0.0);
      check_db("R7", 1000.0, db);

      // R8: outputs hold, no stray done while idle
      held = db_a;
      extra = 0;
      repeat (12) begin
         @(negedge clk);
         if (done_a || db_a != held || inv_a) extra++;
      end
      chk(extra == 0, "R8", "idle hold", real'(extra), 0.0);

      // R5: start while busy is ignored
      @(negedge clk);
      lin_a = 10'd100;
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      lat = 1;
      repeat (4) begin
         @(negedge clk);
         lat++;
      end
      lin_a = 10'd7;
      start_a = 1'b1;
      @(negedge clk);
      lat++;
      start_a = 1'b0;
      wait_done_a(lat);
      chk(lat == lat_exp, "R5", "latency with busy start", real'(lat), real'(lat_exp));
      check_db("R5", 100.0, db_a);
      extra = 0;
      repeat (lat_exp + 5) begin
         @(negedge clk);
         if (done_a) extra++;
      end
      chk(extra == 0, "R5", "extra done", real'(extra), 0.0);

      // R9: start in the done cycle is accepted
      run_a(50, db, inv, lat);
      check_db("R9", 50.0, db);
      lin_a = 10'd3;
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      lat = 1;
      wait_done_a(lat);
      chk(lat == lat_exp, "R9", "back-to-back latency", real'(lat), real'(lat_exp));
      check_db("R9", 3.0, db_a);

      finish_run();
   end

endmodule